// File: doc/BRIEF.md
# Predicated Lane Writeback Gate

This block sits at the writeback edge of a SIMD lane group. It holds a signed condition code for each lane and checks every issued instruction's predicate against it. It then passes on only the register-write and memory-request strobes of lanes whose predicate holds and which are active in the warp mask. Compare instructions load new condition codes through a per-lane write port. An instruction in the same cycle already sees the new value, so a compare and the predicated instruction that depends on it can go back to back.

A predicated instruction always uses its issue slot. `slot_done` pulses for it whether any lane writes or not. Guarding an if/else with a predicate and its opposite, for example zero and not-zero, runs both arms without a branch. Each active lane commits in exactly one of the two arms. The ALU that produces results and the memory system that consumes requests are outside this block.

Top module: `pred_cc_gate`

## Requirements
- R1: After reset every output is 0 and every lane's condition code is 0.
- R2: With predicate code 0 (always) and issue_valid high, the next cycle's reg_we_out equals reg_we_in AND active_mask, and mem_valid_out equals mem_req_in AND active_mask.
- R3: With predicate code 1 (never), no lane asserts reg_we_out or mem_valid_out in the next cycle.
- R4: Predicate code 2 enables a lane whose condition code equals zero. Predicate code 3 enables a lane whose condition code is non-zero.
- R5: Predicate code 4 enables a lane whose condition code, read as signed two's complement, is greater than or equal to zero. Predicate code 5 enables a lane whose condition code is less than zero.
- R6: Predicate codes 6 and 7 are reserved and enable no lane.
- R7: A lane that is 0 in active_mask never asserts reg_we_out or mem_valid_out, whatever its predicate.
- R8: slot_done is high exactly in the cycle after each cycle with issue_valid high, whatever the predicate outcome.
- R9: result_out carries, one cycle later, the result_in of the previous cycle unchanged on all lanes.
- R10: A lane with cc_we high loads cc_wdata at the clock edge. A predicate evaluated in that same cycle already uses the new value. Lanes with cc_we low keep their code.
- R11: For any state, the enables from a predicate and from its complement (2/3 or 4/5) are disjoint, and their OR equals active_mask when all strobes are set.
- R12: With issue_valid low, reg_we_out and mem_valid_out are all 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | An instruction occupies this cycle |
| pred_sel | input | 3 | Predicate code (0 always, 1 never, 2 zero, 3 non-zero, 4 ≥0, 5 <0, 6-7 never) |
| active_mask | input | LANES | Warp active lanes |
| reg_we_in | input | LANES | Requested register writes |
| mem_req_in | input | LANES | Requested memory loads/stores |
| result_in | input | LANES*DW | Operation results, lane 0 in the low bits |
| cc_we | input | LANES | Condition code write per lane |
| cc_wdata | input | LANES*CCW | New condition codes, lane 0 in the low bits |
| slot_done | output | 1 | Issue slot consumed (one cycle after issue) |
| reg_we_out | output | LANES | Gated register writes |
| mem_valid_out | output | LANES | Gated memory requests |
| result_out | output | LANES*DW | Registered results |

## Verification
Every output is registered once. The gated enables, slot_done and result_out for an input cycle therefore appear after the next rising edge. A condition code write takes effect in the cycle it is presented. The bench drives inputs on the falling edge and computes the expected outputs from its own per-lane condition code model, including the same-cycle write. It compares them on the following falling edge, one cycle later, so each cycle's stimulus is checked exactly once against its own results. The complementary-predicate check captures two consecutive result cycles and compares them with each other and with the mask.

// File: rtl/pred_cc_gate.sv
module pred_cc_gate #(
  parameter int LANES = 8,
  parameter int CCW   = 8,
  parameter int DW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_valid,
  input  logic [2:0]             pred_sel,
  input  logic [LANES-1:0]       active_mask,
  input  logic [LANES-1:0]       reg_we_in,
  input  logic [LANES-1:0]       mem_req_in,
  input  logic [LANES*DW-1:0]    result_in,
  input  logic [LANES-1:0]       cc_we,
  input  logic [LANES*CCW-1:0]   cc_wdata,
  output logic                   slot_done,
  output logic [LANES-1:0]       reg_we_out,
  output logic [LANES-1:0]       mem_valid_out,
  output logic [LANES*DW-1:0]    result_out
);

  localparam logic [2:0] P_ALWAYS = 3'd0;
  localparam logic [2:0] P_NEVER  = 3'd1;
  localparam logic [2:0] P_ZERO   = 3'd2;
  localparam logic [2:0] P_NZERO  = 3'd3;
  localparam logic [2:0] P_GEZ    = 3'd4;
  localparam logic [2:0] P_LTZ    = 3'd5;

  function automatic logic pred_ok(input logic [2:0] sel, input logic signed [CCW-1:0] cc);
    case (sel)
      P_ALWAYS: pred_ok = 1'b1;
      P_NEVER:  pred_ok = 1'b0;
      P_ZERO:   pred_ok = (cc == '0);
      P_NZERO:  pred_ok = (cc != '0);
      P_GEZ:    pred_ok = !cc[CCW-1];
      P_LTZ:    pred_ok = cc[CCW-1];
      default:  pred_ok = 1'b0;
    endcase
  endfunction

  logic [LANES*CCW-1:0] cc_q, cc_cur;
  logic [LANES-1:0]     pass, lane_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cc_cur[g*CCW +: CCW] = cc_we[g] ? cc_wdata[g*CCW +: CCW] : cc_q[g*CCW +: CCW];
    assign pass[g] = pred_ok(pred_sel, cc_cur[g*CCW +: CCW]);
  end

  assign lane_en = {LANES{issue_valid}} & active_mask & pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= '0;
    else        cc_q <= cc_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_done     <= 1'b0;
      reg_we_out    <= '0;
      mem_valid_out <= '0;
      result_out    <= '0;
    end else begin
      slot_done     <= issue_valid;
      reg_we_out    <= lane_en & reg_we_in;
      mem_valid_out <= lane_en & mem_req_in;
      result_out    <= result_in;
    end
  end

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (reg_we_out == '0 && mem_valid_out == '0));

  assert_inactive_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (((reg_we_out | mem_valid_out) & ~$past(active_mask)) == '0));

  assert_slot_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> slot_done);

  assert_never_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && pred_sel == P_NEVER) |=> (reg_we_out == '0 && mem_valid_out == '0));

  assert_we_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_we_out & ~$past(reg_we_in)) == '0 && (mem_valid_out & ~$past(mem_req_in)) == '0));

endmodule

// File: tb/tb_pred_cc_gate.sv
module tb_pred_cc_gate;
  localparam int L = 8, C = 8, D = 16;

  logic clk = 0, rst_n = 0;
  logic iv = 0;
  logic [2:0] sel = 0;
  logic [L-1:0] am = 0, we = 0, mr = 0, cwe = 0;
  logic [L*D-1:0] res = 0;
  logic [L*C-1:0] cwd = 0;
  logic slot_done;
  logic [L-1:0] reg_we_out, mem_valid_out;
  logic [L*D-1:0] result_out;

  pred_cc_gate #(.LANES(L), .CCW(C), .DW(D)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(iv), .pred_sel(sel),
    .active_mask(am), .reg_we_in(we), .mem_req_in(mr), .result_in(res),
    .cc_we(cwe), .cc_wdata(cwd), .slot_done(slot_done),
    .reg_we_out(reg_we_out), .mem_valid_out(mem_valid_out), .result_out(result_out));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int ccm[L];
  string phase = "";
  logic [L-1:0] e_we, e_mr;
  logic e_slot;
  logic [L*D-1:0] e_res;

  task automatic chk(input string tag, input string what, input logic [L*D-1:0] got, input logic [L*D-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic bit model_pass(input logic [2:0] s, input int c);
    case (s)
      0: return 1;
      2: return c == 0;
      3: return c != 0;
      4: return c >= 0;
      5: return c < 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic v, input logic [2:0] s);
    if (phase != "") return phase;
    if (!v) return "R12";
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] s, input logic [L-1:0] a, input logic [L-1:0] w,
                      input logic [L-1:0] m, input logic [L-1:0] ce, input logic [L*C-1:0] cd,
                      input logic [L*D-1:0] r);
    string t;
    iv = v; sel = s; am = a; we = w; mr = m; cwe = ce; cwd = cd; res = r;
    for (int l = 0; l < L; l++) begin
      int c;
      c = ce[l] ? int'($signed(cd[l*C +: C])) : ccm[l];
      ccm[l] = c;
      e_we[l] = v & a[l] & w[l] & model_pass(s, c);
      e_mr[l] = v & a[l] & m[l] & model_pass(s, c);
    end
    e_slot = v; e_res = r;
    t = tag_of(v, s);
    @(posedge clk); @(negedge clk);
    chk(t, "reg_we_out", L*D'(reg_we_out), L*D'(e_we));
    chk(t, "mem_valid_out", L*D'(mem_valid_out), L*D'(e_mr));
    chk("R8", "slot_done", L*D'(slot_done), L*D'(e_slot));
    chk("R9", "result_out", result_out, e_res);
  endtask

  function automatic logic [L*C-1:0] fill(input int v);
    logic [L*C-1:0] x;
    for (int l = 0; l < L; l++) x[l*C +: C] = C'(v);
    return x;
  endfunction

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [L-1:0] arm_a;
    for (int l = 0; l < L; l++) ccm[l] = 0;
    repeat (2) @(negedge clk);
    // R1: outputs zero in reset and after release
    chk("R1", "reg_we_out", L*D'(reg_we_out), 0);
    chk("R1", "mem_valid_out", L*D'(mem_valid_out), 0);
    chk("R1", "slot_done", L*D'(slot_done), 0);
    chk("R1", "result_out", result_out, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: codes reset to zero, so zero predicate enables every active lane
    phase = "R1";
    step(1, 2, 8'hFF, 8'hFF, 8'hFF, 0, 0, 128'h1234);
    // R10: same-cycle write is forwarded; lanes 0-3 get 5, others stay 0
    phase = "R10";
    step(1, 3, 8'hFF, 8'hFF, 8'h0F, 8'h0F, fill(5), 128'h5);
    step(1, 2, 8'hFF, 8'hFF, 8'hFF, 0, fill(9), 128'h6);
    step(1, 5, 8'hFF, 8'hFF, 8'hFF, 8'hF0, fill(-3), 128'h7);
    step(1, 4, 8'hFF, 8'hFF, 8'hFF, 0, 0, 128'h8);
    // R7: no active lane, always predicate
    phase = "R7";
    step(1, 0, 8'h00, 8'hFF, 8'hFF, 0, 0, 128'h9);
    step(1, 0, 8'hA5, 8'hFF, 8'hFF, 0, 0, 128'hA);
    // R3 / R6
    phase = "R3";
    step(1, 1, 8'hFF, 8'hFF, 8'hFF, 0, 0, 128'hB);
    phase = "R6";
    step(1, 6, 8'hFF, 8'hFF, 8'hFF, 0, 0, 128'hC);
    step(1, 7, 8'hFF, 8'hFF, 8'hFF, 0, 0, 128'hD);
    // R12: idle cycle with strobes raised
    phase = "R12";
    step(0, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0, 128'hE);
    // R11: if/else arms with complementary predicates
    phase = "R11";
    step(1, 2, 8'h7E, 8'hFF, 8'hFF, 8'h3C, {8'd0, 8'd1, 8'd0, 8'd2, 8'd0, 8'hFF, 8'd0, 8'd0}, 0);
    arm_a = reg_we_out;
    step(1, 3, 8'h7E, 8'hFF, 8'hFF, 0, 0, 0);
    chk("R11", "zero/nonzero overlap", L*D'(arm_a & reg_we_out), 0);
    chk("R11", "zero/nonzero cover", L*D'(arm_a | reg_we_out), L*D'(8'h7E));
    step(1, 4, 8'hDB, 8'hFF, 8'hFF, 0, 0, 0);
    arm_a = reg_we_out;
    step(1, 5, 8'hDB, 8'hFF, 8'hFF, 0, 0, 0);
    chk("R11", "ge/lt overlap", L*D'(arm_a & reg_we_out), 0);
    chk("R11", "ge/lt cover", L*D'(arm_a | reg_we_out), L*D'(8'hDB));
    // mixed traffic, tags from predicate code
    phase = "";
    for (int k = 0; k < 400; k++) begin
      logic [L*C-1:0] d;
      for (int l = 0; l < L; l++) d[l*C +: C] = C'(int'($urandom_range(0, 4)) - 2);
      step(($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom),
           8'($urandom), 8'($urandom), d, {$urandom, $urandom, $urandom, $urandom});
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule